// File: doc/BRIEF.md
# Watch Timer with Buzzer Tone Output

A free-running binary divider clocked by the system clock, intended for a 4.194304 MHz input so that every ratio is an exact power of two. From one counter it produces two things at once. The first is a periodic interval request, which the block sets in hardware and software clears. The second is a square-wave buzzer tone with four selectable pitches. An 8-bit mode word, written through a simple write strobe, switches the timer on or off and selects the interval length and the tone.

The enable bit is held by a two-state machine. In `ST_OFF` the divider is held at zero and the tone is low. `ST_RUN` advances the divider once per clock. A mode write with bit 0 set moves `ST_OFF` to `ST_RUN` (transition *start*). A mode write with bit 0 clear moves `ST_RUN` to `ST_OFF` (transition *halt*). Any other write keeps the current state.

The request flag is a second two-state machine. `FLG_IDLE` moves to `FLG_PEND` on an interval expiry (transition *expire*). `FLG_PEND` returns to `FLG_IDLE` on a clear strobe that does not coincide with an expiry (transition *ack*). An expiry in `FLG_PEND` keeps the flag pending.

Top module: `wt_watch_timer`

## Requirements
- R1: After reset the timer is in `ST_OFF`, the mode fields are zero, `intv_req` is 0 and `buzz_out` is 0.
- R2: While bit 0 of the last written mode is 0, `buzz_out` is 0 and no expiry sets `intv_req`.
- R3: With mode bit 1 = 0 (long interval), `intv_req` first rises 2^LONG_LOG2 clock edges after the edge that wrote the enabling mode. With the defaults this is 2^21 clocks, or 0.5 s.
- R4: With mode bit 1 = 1 (short interval), `intv_req` first rises 2^SHORT_LOG2 edges after the enabling write. With the defaults this is 2^14 clocks, about 3.91 ms.
- R5: While running, expiries repeat every interval period, measured from the enabling write.
- R6: Mode bits [3:2] form a tone code t. `buzz_out` is a 50% square wave with a period of 2^(TONE_LOG2-t) clocks. It first rises 2^(TONE_LOG2-1-t) edges after the enabling write. With the defaults the tones are 2, 4, 8 and 16 kHz.
- R7: Once set, `intv_req` stays 1 until `req_clr` is sampled high. A clear with no coincident expiry makes it 0 at the next edge.
- R8: When `req_clr` coincides with an expiry edge, `intv_req` remains 1.
- R9: A halt resets the divider. After a halt and a new start, all interval and tone timing restarts from zero.
- R10: Mode bits [7:4] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 8 | Mode word: [0] enable, [1] short interval, [3:2] tone code, [7:4] ignored |
| req_clr | input | 1 | Software clear of the interval request |
| intv_req | output | 1 | Interval request flag |
| buzz_out | output | 1 | Buzzer square wave |

## Verification
Two conditions are hard to create from the ports. The first is a clear strobe that lands on exactly the clock edge where the divider wraps. The second is a halt that lands partway through a count. The bench runs a cycle model of the divider in parallel with the design. It uses that model to step until the next edge is known to be an expiry, then raises `req_clr` on that one edge. Interval and tone limits are shortened through parameters, so that many wraps, random mode rewrites and random clears fit in a short run. Directed first-edge measurements then pin down each period exactly.

// File: rtl/wt_pkg.sv
package wt_pkg;

    // Mode word layout: [7:4] ignored, [3:2] tone code, [1] short interval, [0] enable
    typedef struct packed {
        logic [3:0] unused;
        logic [1:0] tone_sel;
        logic       short_sel;
        logic       enable;
    } wt_mode_t;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } wt_run_state_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } wt_flag_state_e;

    localparam int TONE_COUNT = 4;

endpackage

// File: rtl/wt_mode_reg.sv
module wt_mode_reg
    import wt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       short_sel,
    output logic [1:0] tone_sel
);

    wt_mode_t wr_mode;
    logic       short_q;
    logic [1:0] tone_q;

    assign wr_mode = wt_mode_t'(wr_data);

    // The enable bit lives in the divider state machine; the unused field is dropped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_q <= 1'b0;
            tone_q  <= 2'b00;
        end else if (wr_en) begin
            short_q <= wr_mode.short_sel;
            tone_q  <= wr_mode.tone_sel;
        end
    end

    assign short_sel = short_q;
    assign tone_sel  = tone_q;

endmodule

// File: rtl/wt_divider.sv
module wt_divider
    import wt_pkg::*;
#(
    parameter int LONG_LOG2  = 21,
    parameter int SHORT_LOG2 = 14,
    parameter int TONE_LOG2  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_enable,
    input  logic       short_sel,
    input  logic [1:0] tone_sel,
    output logic       running,
    output logic       expire,
    output logic       buzz
);

    localparam int CNT_W = LONG_LOG2;

    wt_run_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [TONE_COUNT-1:0] taps;
    logic short_wrap, long_wrap;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions: start (OFF->RUN), halt (RUN->OFF)
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                ST_OFF: if (wr_enable)  state_d = ST_RUN;
                ST_RUN: if (!wr_enable) state_d = ST_OFF;
            endcase
        end
    end

    // Divider chain: counts while running, held at zero otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
        else                       cnt_q <= '0;
    end

    // Tone taps: code t picks bit TONE_LOG2-1-t
    for (genvar t = 0; t < TONE_COUNT; t++) begin : g_tap
        assign taps[t] = cnt_q[TONE_LOG2-1-t];
    end

    assign short_wrap = &cnt_q[SHORT_LOG2-1:0];
    assign long_wrap  = &cnt_q;

    // Output process
    always_comb begin
        expire = 1'b0;
        buzz   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                expire = 1'b0;
                buzz   = 1'b0;
            end
            ST_RUN: begin
                expire = short_sel ? short_wrap : long_wrap;
                buzz   = taps[tone_sel];
            end
        endcase
    end

    assign running = (state_q == ST_RUN);

endmodule

// File: rtl/wt_req_flag.sv
module wt_req_flag
    import wt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    output logic req
);

    wt_flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: expire (IDLE->PEND), ack (PEND->IDLE); expiry beats clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (expire)         state_d = FLG_PEND;
            FLG_PEND: if (clr && !expire) state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_IDLE: req = 1'b0;
            FLG_PEND: req = 1'b1;
        endcase
    end

endmodule

// File: rtl/wt_watch_timer.sv
module wt_watch_timer
    import wt_pkg::*;
#(
    parameter int LONG_LOG2  = 21,
    parameter int SHORT_LOG2 = 14,
    parameter int TONE_LOG2  = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [7:0] mode_wdata,
    input  logic       req_clr,
    output logic       intv_req,
    output logic       buzz_out
);

    logic       short_sel;
    logic [1:0] tone_sel;
    logic       running;
    logic       expire;

    wt_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mode_we),
        .wr_data   (mode_wdata),
        .short_sel (short_sel),
        .tone_sel  (tone_sel)
    );

    wt_divider #(
        .LONG_LOG2  (LONG_LOG2),
        .SHORT_LOG2 (SHORT_LOG2),
        .TONE_LOG2  (TONE_LOG2)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mode_we),
        .wr_enable (mode_wdata[0]),
        .short_sel (short_sel),
        .tone_sel  (tone_sel),
        .running   (running),
        .expire    (expire),
        .buzz      (buzz_out)
    );

    wt_req_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .clr    (req_clr),
        .req    (intv_req)
    );

endmodule

// File: rtl/wt_watch_timer_chk.sv
module wt_watch_timer_chk #(
    parameter int LONG_LOG2  = 21,
    parameter int SHORT_LOG2 = 14,
    parameter int TONE_LOG2  = 11
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_we,
    input logic [7:0] mode_wdata,
    input logic       req_clr,
    input logic       intv_req,
    input logic       buzz_out
);

    logic                 sh_en, sh_short;
    logic [1:0]           sh_tone;
    logic [LONG_LOG2-1:0] ck_cnt;
    logic                 tap_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_en    <= 1'b0;
            sh_short <= 1'b0;
            sh_tone  <= 2'b00;
            ck_cnt   <= '0;
        end else begin
            ck_cnt <= sh_en ? ck_cnt + 1'b1 : '0;
            if (mode_we) begin
                sh_en    <= mode_wdata[0];
                sh_short <= mode_wdata[1];
                sh_tone  <= mode_wdata[3:2];
            end
        end
    end

    always_comb tap_val = ck_cnt[TONE_LOG2-1-int'(sh_tone)];

    AST_OFF_BUZZ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_en |-> !buzz_out); // R2
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!intv_req && !sh_en) |=> !intv_req); // R2
    AST_LONG_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_en && !sh_short && (&ck_cnt)) |=> intv_req); // R3
    AST_SHORT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_en && sh_short && (&ck_cnt[SHORT_LOG2-1:0])) |=> intv_req); // R4
    AST_TONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        sh_en |-> (buzz_out == tap_val)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (intv_req && !req_clr) |=> intv_req); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (intv_req && req_clr && !sh_en) |=> !intv_req); // R7

endmodule

bind wt_watch_timer wt_watch_timer_chk #(
    .LONG_LOG2  (LONG_LOG2),
    .SHORT_LOG2 (SHORT_LOG2),
    .TONE_LOG2  (TONE_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .req_clr    (req_clr),
    .intv_req   (intv_req),
    .buzz_out   (buzz_out)
);

// File: tb/wt_watch_timer_tb_top.sv
module wt_watch_timer_tb_top;

    localparam int LG = 10;
    localparam int SH = 5;
    localparam int TN = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = 8'h00;
    logic       req_clr = 1'b0;
    logic       intv_req;
    logic       buzz_out;

    always #10 clk = ~clk;

    wt_watch_timer #(
        .LONG_LOG2  (LG),
        .SHORT_LOG2 (SH),
        .TONE_LOG2  (TN)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .req_clr    (req_clr),
        .intv_req   (intv_req),
        .buzz_out   (buzz_out)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]    m_mode = 8'h00;
    logic [LG-1:0] m_cnt = '0;
    logic          m_flag = 1'b0;
    logic          obs_flag = 1'b0;
    logic          obs_buzz = 1'b0;

    function automatic logic f_expire(input logic [7:0] md, input logic [LG-1:0] c);
        if (!md[0]) return 1'b0;
        if (md[1]) return &c[SH-1:0];
        return &c;
    endfunction

    function automatic logic f_buzz(input logic [7:0] md, input logic [LG-1:0] c);
        if (!md[0]) return 1'b0;
        return c[TN-1-int'(md[3:2])];
    endfunction

    task automatic chk(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] wd, input logic clr, input string tag);
        logic nf;
        @(negedge clk);
        obs_flag = intv_req;
        obs_buzz = buzz_out;
        chk(intv_req, m_flag, {tag, " intv_req"});
        chk(buzz_out, f_buzz(m_mode, m_cnt), {tag, " buzz_out"});
        mode_we    = we;
        mode_wdata = wd;
        req_clr    = clr;
        @(posedge clk);
        nf     = f_expire(m_mode, m_cnt) | (m_flag & ~clr);
        m_cnt  = m_mode[0] ? m_cnt + 1'b1 : '0;
        m_flag = nf;
        if (we) m_mode = wd;
    endtask

    // Halt, clear the flag, then write the enabling mode word
    task automatic restart(input logic [7:0] md, input string tag);
        step(1'b1, 8'h00, 1'b0, tag);
        step(1'b0, 8'h00, 1'b1, tag);
        step(1'b0, 8'h00, 1'b0, tag);
        step(1'b1, md, 1'b0, tag);
    endtask

    // Step until the chosen output is first seen high; step k observes k-1 edges after the write
    task automatic first_rise(input bit want_buzz, input int exp_edges, input string tag);
        int seen = 0;
        for (int k = 1; k <= exp_edges + 8; k++) begin
            step(1'b0, 8'h00, 1'b0, tag);
            if (want_buzz ? obs_buzz : obs_flag) begin
                seen = k - 1;
                break;
            end
        end
        n_checks++;
        if (seen != exp_edges) begin
            n_fail++;
            $display("FAIL %s first rise actual=%0d expected=%0d", tag, seen, exp_edges);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(intv_req, 1'b0, "R1 intv_req after reset");
        chk(buzz_out, 1'b0, "R1 buzz_out after reset");

        // R2: disabled, with writes that keep enable low and random clears
        for (int i = 0; i < 200; i++)
            step((i % 17) == 0, 8'hFE, 1'($urandom % 2), "R2 disabled");
        chk(obs_flag, 1'b0, "R2 no request while off");

        // R4 and R3: first expiry of each interval
        restart(8'h03, "R4");
        first_rise(1'b0, 1 << SH, "R4 short interval");
        restart(8'h01, "R3");
        first_rise(1'b0, 1 << LG, "R3 long interval");

        // R7: flag holds without clear
        for (int i = 0; i < 40; i++) step(1'b0, 8'h00, 1'b0, "R7 sticky");
        chk(obs_flag, 1'b1, "R7 flag held");
        step(1'b0, 8'h00, 1'b1, "R7 clear");
        step(1'b0, 8'h00, 1'b0, "R7 clear");
        chk(obs_flag, 1'b0, "R7 flag cleared");

        // R6: each tone code
        for (int t = 0; t < 4; t++) begin
            restart(8'((t << 2) | 1), "R6");
            first_rise(1'b1, 1 << (TN - 1 - t), "R6 tone first rise");
            for (int i = 0; i < 3 * (1 << (TN - t)); i++) step(1'b0, 8'h00, 1'b0, "R6 tone duty");
        end

        // R5: repeated short expiries with clears on each request
        restart(8'h07, "R5");
        for (int i = 0; i < 300; i++) step(1'b0, 8'h00, obs_flag, "R5 periodic");

        // R8: clear on the exact expiry edge
        for (int r = 0; r < 3; r++) begin
            while (!f_expire(m_mode, m_cnt)) step(1'b0, 8'h00, 1'b0, "R8 approach");
            step(1'b0, 8'h00, 1'b1, "R8 clear at expiry");
            step(1'b0, 8'h00, 1'b0, "R8 after");
            chk(obs_flag, 1'b1, "R8 expiry wins over clear");
            step(1'b0, 8'h00, 1'b1, "R8 tidy");
        end

        // R9: halt mid-count then start again
        restart(8'h03, "R9");
        for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 1'b0, "R9 partial");
        step(1'b1, 8'h02, 1'b1, "R9 halt");
        step(1'b1, 8'h03, 1'b0, "R9 start");
        first_rise(1'b0, 1 << SH, "R9 restart from zero");

        // R10: upper bits set make no difference
        restart(8'hF3, "R10");
        first_rise(1'b0, 1 << SH, "R10 ignored bits interval");
        restart(8'hA5, "R10");
        first_rise(1'b1, 1 << (TN - 2), "R10 ignored bits tone");

        // Random traffic across all modes
        for (int i = 0; i < 4000; i++) begin
            logic       we;
            logic [7:0] wd;
            we = (($urandom % 48) == 0);
            wd = 8'($urandom);
            wd[0] = (($urandom % 4) != 0);
            step(we, wd, (($urandom % 12) == 0), "R5 R6 R7 R10 random");
        end

        step(1'b0, 8'h00, 1'b0, "final");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule